// File: doc/BRIEF.md
# Power-State Phase-Shedding Controller

This block sits behind the voltage-command packet receiver of a two-rail regulator controller. Each time the receiver finishes a packet it pulses an update strobe. With that strobe it presents the two rail-select bits from the packet, the two active-low power-state flags and the 3-bit load-line trim code. For each selected rail the block registers these values. It then drives a mode and an enable for every phase of that rail. It also turns the trim code into a signed percentage adjustment and a load-line-off flag for the downstream slope logic.

The core rail has three phases and the auxiliary rail has two. A phase can run in full continuous conduction, run in diode emulation, or be switched off (tri-stated). The deeper power-state flag takes priority over the shallower one. When the deeper flag is asserted, only phase 0 keeps running, in diode emulation, and the rail's other phases are shed. When the deeper flag is deasserted, every phase returns to continuous conduction, whatever the shallower flag says. The two flags may arrive in any order.

Top module: `psi_phase_ctl`

## Requirements
- R1: After reset every phase of both rails is in continuous conduction (mode 2'b01) with its enable high, both trim percentages are 0, and both load-line-off flags are low.
- R2: When an update with `sel_core`=1 carries `psi_deep_n`=0, the cycle after the strobe edge shows core phase 0 in diode emulation (mode 2'b10) and core phases 1 and 2 off (mode 2'b00).
- R3: When an update with `sel_aux`=1 carries `psi_deep_n`=0, the cycle after the strobe edge shows aux phase 0 in diode emulation and aux phase 1 off.
- R4: When an update for a rail carries `psi_deep_n`=1, every phase of that rail is in continuous conduction afterwards, whether `psi_light_n` is 0 or 1.
- R5: `psi_light_n` has no effect on the phase outputs. Asserting it while the deep flag is asserted leaves the single-phase diode-emulation state unchanged.
- R6: A rail's registered state changes only on an `upd` pulse with that rail's select bit set. With `upd` low, or with the rail's select bit clear, its outputs hold.
- R7: Trim code to output mapping: 3'b000 gives off=1 and pct=0; 001 gives -40; 010 gives -20; 011 gives 0; 100 gives +20; 101 gives +40; 110 gives +60; 111 gives +80. The pct output is signed 8-bit two's complement.
- R8: Each rail holds its own trim. An update for one rail leaves the other rail's trim outputs unchanged.
- R9: Phase mode encoding is 2'b00 off, 2'b01 continuous conduction, 2'b10 diode emulation. A phase's enable is high exactly when its mode is not off.
- R10: An update with both select bits set applies the same flags and trim to both rails in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| upd | input | 1 | One-cycle update strobe from the packet receiver |
| sel_core | input | 1 | Packet applies to the core rail |
| sel_aux | input | 1 | Packet applies to the auxiliary rail |
| psi_deep_n | input | 1 | Deep power-state flag, active low, takes priority |
| psi_light_n | input | 1 | Shallow power-state flag, active low |
| trim | input | 3 | Load-line trim code |
| core_mode | output | 6 | Core phase modes, 2 bits per phase, phase 0 in bits 1:0 |
| core_en | output | 3 | Core phase enables, bit i is phase i |
| aux_mode | output | 4 | Aux phase modes, 2 bits per phase, phase 0 in bits 1:0 |
| aux_en | output | 2 | Aux phase enables |
| core_pct | output | 8 | Core load-line adjustment in percent, signed |
| core_ll_off | output | 1 | Core load line disabled |
| aux_pct | output | 8 | Aux load-line adjustment in percent, signed |
| aux_ll_off | output | 1 | Aux load line disabled |

## Verification
The assertions assume that `upd` is a single-cycle pulse sampled on the rising edge, and that the select, flag and trim inputs are valid whenever `upd` is high. Outside a strobe they check only that the outputs hold, so those inputs may take any value. The stimulus changes every input just after the falling edge. It deliberately toggles flags, selects and trim while `upd` is low, and it also pulses `upd` with both selects clear, so the hold checks see real input activity. The flag pairs are applied in both orders: deep then shallow, shallow then deep, and deep released while shallow stays asserted.

// File: rtl/psi_phase_ctl.sv
module psi_phase_ctl #(
  parameter int CORE_PH = 3,
  parameter int AUX_PH  = 2,
  parameter int PCT_W   = 8,
  parameter int STEP    = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    upd,
  input  logic                    sel_core,
  input  logic                    sel_aux,
  input  logic                    psi_deep_n,
  input  logic                    psi_light_n,
  input  logic [2:0]              trim,
  output logic [2*CORE_PH-1:0]    core_mode,
  output logic [CORE_PH-1:0]      core_en,
  output logic [2*AUX_PH-1:0]     aux_mode,
  output logic [AUX_PH-1:0]       aux_en,
  output logic signed [PCT_W-1:0] core_pct,
  output logic                    core_ll_off,
  output logic signed [PCT_W-1:0] aux_pct,
  output logic                    aux_ll_off
);

  localparam logic [1:0] M_OFF = 2'b00;
  localparam logic [1:0] M_CCM = 2'b01;
  localparam logic [1:0] M_DE  = 2'b10;
  localparam logic [2:0] TRIM_NEUTRAL = 3'b011;

  // level bit 1: deep flag asserted, bit 0: light flag asserted
  logic [1:0] core_lvl, aux_lvl;
  logic [2:0] core_trim, aux_trim;

  wire core_we = upd && sel_core;
  wire aux_we  = upd && sel_aux;
  wire [1:0] lvl_in = {~psi_deep_n, ~psi_light_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_lvl  <= 2'b00;
      aux_lvl   <= 2'b00;
      core_trim <= TRIM_NEUTRAL;
      aux_trim  <= TRIM_NEUTRAL;
    end else begin
      if (core_we) begin
        core_lvl  <= lvl_in;
        core_trim <= trim;
      end
      if (aux_we) begin
        aux_lvl  <= lvl_in;
        aux_trim <= trim;
      end
    end
  end

  function automatic logic shed(input logic [1:0] lvl);
    case (lvl)
      2'b10, 2'b11: shed = 1'b1;
      default:      shed = 1'b0;
    endcase
  endfunction

  function automatic logic [1:0] ph_mode(input logic shd, input int idx);
    if (!shd)          ph_mode = M_CCM;
    else if (idx == 0) ph_mode = M_DE;
    else               ph_mode = M_OFF;
  endfunction

  function automatic logic signed [PCT_W-1:0] trim_pct(input logic [2:0] c);
    case (c)
      3'd1:    trim_pct = PCT_W'(-2 * STEP);
      3'd2:    trim_pct = PCT_W'(-1 * STEP);
      3'd4:    trim_pct = PCT_W'(1 * STEP);
      3'd5:    trim_pct = PCT_W'(2 * STEP);
      3'd6:    trim_pct = PCT_W'(3 * STEP);
      3'd7:    trim_pct = PCT_W'(4 * STEP);
      default: trim_pct = '0;
    endcase
  endfunction

  wire core_shed = shed(core_lvl);
  wire aux_shed  = shed(aux_lvl);

  for (genvar i = 0; i < CORE_PH; i++) begin : g_core
    assign core_mode[2*i +: 2] = ph_mode(core_shed, i);
    assign core_en[i]          = !core_shed || (i == 0);
  end

  for (genvar i = 0; i < AUX_PH; i++) begin : g_aux
    assign aux_mode[2*i +: 2] = ph_mode(aux_shed, i);
    assign aux_en[i]          = !aux_shed || (i == 0);
  end

  assign core_pct    = trim_pct(core_trim);
  assign aux_pct     = trim_pct(aux_trim);
  assign core_ll_off = (core_trim == 3'b000);
  assign aux_ll_off  = (aux_trim == 3'b000);

endmodule

// File: rtl/psi_phase_ctl_chk.sv
module psi_phase_ctl_chk #(
  parameter int CORE_PH = 3,
  parameter int AUX_PH  = 2,
  parameter int PCT_W   = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    upd,
  input logic                    sel_core,
  input logic                    sel_aux,
  input logic                    psi_deep_n,
  input logic [2:0]              trim,
  input logic [2*CORE_PH-1:0]    core_mode,
  input logic [CORE_PH-1:0]      core_en,
  input logic [2*AUX_PH-1:0]     aux_mode,
  input logic [AUX_PH-1:0]       aux_en,
  input logic signed [PCT_W-1:0] core_pct,
  input logic                    core_ll_off,
  input logic signed [PCT_W-1:0] aux_pct,
  input logic                    aux_ll_off
);

  // R6
  core_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd && sel_core) |=> $stable(core_mode) && $stable(core_pct) && $stable(core_ll_off));

  // R6
  aux_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd && sel_aux) |=> $stable(aux_mode) && $stable(aux_pct) && $stable(aux_ll_off));

  // R2
  core_shed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd && sel_core && !psi_deep_n |=> core_mode[1:0] == 2'b10 && $countones(core_en) == 1);

  // R3
  aux_shed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd && sel_aux && !psi_deep_n |=> aux_mode[1:0] == 2'b10 && $countones(aux_en) == 1);

  // R4
  core_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd && sel_core && psi_deep_n |=> &core_en);

  // R4
  aux_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd && sel_aux && psi_deep_n |=> &aux_en);

  // R7
  core_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd && sel_core && trim == 3'b000 |=> core_ll_off && core_pct == 0);

  // R7
  core_neutral_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd && sel_core && trim == 3'b011 |=> !core_ll_off && core_pct == 0);

  for (genvar i = 0; i < CORE_PH; i++) begin : g_cc
    // R9
    core_en_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_en[i] == (core_mode[2*i +: 2] != 2'b00));
  end

  for (genvar i = 0; i < AUX_PH; i++) begin : g_ac
    // R9
    aux_en_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      aux_en[i] == (aux_mode[2*i +: 2] != 2'b00));
  end

endmodule

bind psi_phase_ctl psi_phase_ctl_chk #(.CORE_PH(CORE_PH), .AUX_PH(AUX_PH), .PCT_W(PCT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .upd(upd), .sel_core(sel_core), .sel_aux(sel_aux),
  .psi_deep_n(psi_deep_n), .trim(trim),
  .core_mode(core_mode), .core_en(core_en), .aux_mode(aux_mode), .aux_en(aux_en),
  .core_pct(core_pct), .core_ll_off(core_ll_off), .aux_pct(aux_pct), .aux_ll_off(aux_ll_off)
);

// File: tb/psi_phase_ctl_bench.sv
module psi_phase_ctl_bench;
  logic clk = 0, rst_n = 0;
  logic upd = 0, sel_core = 0, sel_aux = 0, psi_deep_n = 1, psi_light_n = 1;
  logic [2:0] trim = 3'b011;
  logic [5:0] core_mode;
  logic [2:0] core_en;
  logic [3:0] aux_mode;
  logic [1:0] aux_en;
  logic signed [7:0] core_pct, aux_pct;
  logic core_ll_off, aux_ll_off;

  int checks = 0, failures = 0;
  int m_core_deep = 0, m_aux_deep = 0;
  int m_core_trim = 3, m_aux_trim = 3;

  always #4 clk = ~clk;

  psi_phase_ctl u_psi_phase_ctl (
    .clk(clk), .rst_n(rst_n), .upd(upd), .sel_core(sel_core), .sel_aux(sel_aux),
    .psi_deep_n(psi_deep_n), .psi_light_n(psi_light_n), .trim(trim),
    .core_mode(core_mode), .core_en(core_en), .aux_mode(aux_mode), .aux_en(aux_en),
    .core_pct(core_pct), .core_ll_off(core_ll_off), .aux_pct(aux_pct), .aux_ll_off(aux_ll_off)
  );

  function automatic int exp_pct(int code);
    return (code == 0) ? 0 : (code - 3) * 20;
  endfunction

  function automatic logic [1:0] exp_mode(int deep, int idx);
    if (deep == 0) return 2'b01;
    return (idx == 0) ? 2'b10 : 2'b00;
  endfunction

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare(string req);
    logic [5:0] cm = '0;
    logic [2:0] ce = '0;
    logic [3:0] am = '0;
    logic [1:0] ae = '0;
    for (int i = 0; i < 3; i++) begin
      cm[2*i +: 2] = exp_mode(m_core_deep, i);
      ce[i] = (exp_mode(m_core_deep, i) != 2'b00);
    end
    for (int i = 0; i < 2; i++) begin
      am[2*i +: 2] = exp_mode(m_aux_deep, i);
      ae[i] = (exp_mode(m_aux_deep, i) != 2'b00);
    end
    chk(req, int'(core_mode), int'(cm), "core_mode");
    chk(req, int'(core_en), int'(ce), "core_en");
    chk(req, int'(aux_mode), int'(am), "aux_mode");
    chk(req, int'(aux_en), int'(ae), "aux_en");
    chk(req, int'(core_pct), exp_pct(m_core_trim), "core_pct");
    chk(req, int'(core_ll_off), int'(m_core_trim == 0), "core_ll_off");
    chk(req, int'(aux_pct), exp_pct(m_aux_trim), "aux_pct");
    chk(req, int'(aux_ll_off), int'(m_aux_trim == 0), "aux_ll_off");
  endtask

  // drive at falling edge, model updates at rising edge, compare at next falling edge
  task automatic cyc(string req, logic u, logic sc, logic sa, logic d, logic l, logic [2:0] t);
    upd = u; sel_core = sc; sel_aux = sa; psi_deep_n = d; psi_light_n = l; trim = t;
    @(posedge clk);
    if (u && sc) begin m_core_deep = !d; m_core_trim = int'(t); end
    if (u && sa) begin m_aux_deep = !d; m_aux_trim = int'(t); end
    @(negedge clk);
    compare(req);
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1;
    @(negedge clk);
    compare("R1");
    cyc("R2", 1, 1, 0, 0, 1, 3'd3);
    cyc("R6", 0, 1, 1, 1, 0, 3'd7);
    cyc("R3", 1, 0, 1, 0, 1, 3'd3);
    cyc("R5", 1, 1, 0, 0, 0, 3'd3);
    cyc("R4", 1, 1, 0, 1, 0, 3'd3);
    cyc("R4", 1, 0, 1, 1, 0, 3'd3);
    cyc("R5", 1, 0, 1, 1, 1, 3'd3);
    cyc("R5", 1, 0, 1, 0, 1, 3'd3);
    cyc("R6", 1, 0, 0, 1, 1, 3'd0);
    cyc("R6", 0, 1, 1, 1, 1, 3'd5);
    for (int c = 0; c < 8; c++) begin
      cyc("R7", 1, 1, 0, 1, 1, 3'(c));
      cyc("R8", 1, 0, 1, 1, 0, 3'(7 - c));
      cyc("R6", 0, 1, 1, 0, 0, 3'(c + 1));
    end
    cyc("R10", 1, 1, 1, 0, 0, 3'd0);
    cyc("R10", 1, 1, 1, 1, 1, 3'd6);
    cyc("R9", 1, 1, 0, 0, 1, 3'd1);
    rst_n = 0;
    m_core_deep = 0; m_aux_deep = 0; m_core_trim = 3; m_aux_trim = 3;
    #1;
    compare("R1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule